// File: doc/BRIEF.md
# Microcoded Shift-and-Add Multiplier Sequencer

This block is the control unit for a shift-and-add binary multiplier. It does not hold the datapath: the accumulator, carry flag, multiplicand and multiplier registers, the adder and the bit counter are elsewhere. The controller gives them four control strobes each cycle and reads back two status bits: the current low bit of the multiplier register and a flag that the bit counter has reached zero. A separate start request begins a multiplication.

The controller is microcoded. A 3-bit control address register selects one 12-bit microword from a small read-only control store. Each microword holds a 2-bit branch-select code, four unencoded strobe bits and two 3-bit successor addresses. A selector then picks one of the two successor addresses from the select code and the status inputs, and that address is loaded into the register at the next edge. The strobes come from the stored word alone. Status bits therefore only steer the sequence, and the controller is a pure Moore machine.

The sequence has five states. IDLE waits for a start request. INIT clears the accumulator and carry and presets the counter. MUL0 tests the multiplier bit. ADD adds the multiplicand. MUL1 shifts, decrements the counter and tests for completion. For an n-bit operand, one multiplication takes 1 + 2n + k cycles from the start request until the sequencer is back in IDLE, where k is the number of ones in the multiplier.

Top module: `usq_seq`

## Requirements
- R1: A synchronous reset loads control address 0 (IDLE) and holds every strobe low.
- R2: At address 0 (IDLE) all strobes are low. The sequencer stays at 0 while goReq is 0 and moves to address 1 (INIT) on the edge where goReq is 1.
- R3: At address 1 (INIT), strInit and strClrCarry are high and strLoad and strShift are low. The next address is always 2 (MUL0).
- R4: At address 2 (MUL0) all strobes are low. The next address is 3 (ADD) when lsbBit is 1 and 4 (MUL1) when lsbBit is 0.
- R5: At address 3 (ADD) only strLoad is high. The next address is always 4 (MUL1).
- R6: At address 4 (MUL1), strShift and strClrCarry are high and strInit and strLoad are low. The next address is 0 (IDLE) when cntZero is 1 and 2 (MUL0) when cntZero is 0.
- R7: At most one of strInit, strLoad and strShift is high in any cycle.
- R8: The strobes depend on the control address alone. Changing goReq, lsbBit or cntZero within a cycle does not change them.
- R9: With a 4-bit datapath, every product of two 4-bit operands is correct. Each multiplication takes 1 + 8 + (ones in the multiplier) cycles from the start request until the sequencer is back at address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| goReq | input | 1 | Start request, sampled in IDLE |
| lsbBit | input | 1 | Low bit of the multiplier register |
| cntZero | input | 1 | Bit counter is zero |
| strInit | output | 1 | Clear the accumulator and preset the counter |
| strLoad | output | 1 | Load adder result into carry and accumulator |
| strClrCarry | output | 1 | Clear the carry flag |
| strShift | output | 1 | Shift carry/accumulator/multiplier right and decrement counter |
| curAddr | output | 3 | Current control address |

## Verification
The branch assertions assume that goReq, lsbBit and cntZero are settled before each rising edge. They also assume that lsbBit and cntZero come from a datapath driven by these strobes, so cntZero rises only after the preset count has been shifted down. The bench keeps to these assumptions in three ways. It changes inputs only on falling edges. It feeds the status bits from its own register model, which the strobes update. It pulses goReq for one cycle, and only while the sequencer is in IDLE. The Moore property is tested by toggling the status inputs in the middle of a cycle and checking that the strobes do not move.

// File: rtl/usq_pkg.sv
package usq_pkg;
  localparam int ADDR_W = 3;
  localparam int SEL_W  = 2;
  localparam int STB_W  = 4;
  localparam int WORD_W = SEL_W + STB_W + 2 * ADDR_W;
  localparam int DEPTH  = 1 << ADDR_W;

  typedef logic [ADDR_W-1:0] addr_t;

  // strobe bits, high bit first: shift, clear carry, load, init
  typedef struct packed {
    logic shiftDec;
    logic clrCarry;
    logic load;
    logic init;
  } strobes_t;

  typedef enum logic [SEL_W-1:0] {
    SEL_ALWAYS = 2'b00,
    SEL_GO     = 2'b01,
    SEL_LSB    = 2'b10,
    SEL_ZERO   = 2'b11
  } sel_e;

  // microword: select, strobes, taken successor, default successor
  typedef struct packed {
    sel_e     sel;
    strobes_t stb;
    addr_t    nxt1;
    addr_t    nxt0;
  } uword_t;

  localparam addr_t A_IDLE = addr_t'(0);
  localparam addr_t A_INIT = addr_t'(1);
  localparam addr_t A_MUL0 = addr_t'(2);
  localparam addr_t A_ADD  = addr_t'(3);
  localparam addr_t A_MUL1 = addr_t'(4);

  localparam strobes_t STB_NONE = '{shiftDec: 1'b0, clrCarry: 1'b0, load: 1'b0, init: 1'b0};

  function automatic uword_t wordFor(int unsigned idx);
    uword_t w;
    w.sel  = SEL_ALWAYS;
    w.stb  = STB_NONE;
    w.nxt1 = A_IDLE;
    w.nxt0 = A_IDLE;
    case (idx)
      0: begin w.sel = SEL_GO;  w.nxt1 = A_INIT; w.nxt0 = A_IDLE; end
      1: begin w.stb.init = 1'b1; w.stb.clrCarry = 1'b1; w.nxt1 = A_MUL0; w.nxt0 = A_MUL0; end
      2: begin w.sel = SEL_LSB; w.nxt1 = A_ADD;  w.nxt0 = A_MUL1; end
      3: begin w.stb.load = 1'b1; w.nxt1 = A_MUL1; w.nxt0 = A_MUL1; end
      4: begin
        w.sel = SEL_ZERO; w.stb.shiftDec = 1'b1; w.stb.clrCarry = 1'b1;
        w.nxt1 = A_IDLE; w.nxt0 = A_MUL0;
      end
      default: ;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/usq_ctl_store.sv
module usq_ctl_store
  import usq_pkg::*;
(
  input  addr_t  rdAddr,
  output uword_t rdWord
);
  uword_t rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    assign rom[i] = wordFor(i);
  end

  assign rdWord = rom[rdAddr];
endmodule

// File: rtl/usq_next_addr.sv
module usq_next_addr
  import usq_pkg::*;
(
  input  sel_e  sel,
  input  addr_t nxt0,
  input  addr_t nxt1,
  input  logic  goReq,
  input  logic  lsbBit,
  input  logic  cntZero,
  output addr_t nxtAddr
);
  logic takeAlt;

  always_comb begin
    case (sel)
      SEL_GO:   takeAlt = goReq;
      SEL_LSB:  takeAlt = lsbBit;
      SEL_ZERO: takeAlt = cntZero;
      default:  takeAlt = 1'b0;
    endcase
  end

  assign nxtAddr = takeAlt ? nxt1 : nxt0;
endmodule

// File: rtl/usq_seq.sv
module usq_seq
  import usq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              goReq,
  input  logic              lsbBit,
  input  logic              cntZero,
  output logic              strInit,
  output logic              strLoad,
  output logic              strClrCarry,
  output logic              strShift,
  output logic [ADDR_W-1:0] curAddr
);
  addr_t  carQ;
  addr_t  nxtAddr;
  uword_t word;

  usq_ctl_store u_store (
    .rdAddr (carQ),
    .rdWord (word)
  );

  usq_next_addr u_next (
    .sel     (word.sel),
    .nxt0    (word.nxt0),
    .nxt1    (word.nxt1),
    .goReq   (goReq),
    .lsbBit  (lsbBit),
    .cntZero (cntZero),
    .nxtAddr (nxtAddr)
  );

  always_ff @(posedge clk) begin
    if (rst) carQ <= A_IDLE;
    else     carQ <= nxtAddr;
  end

  assign curAddr     = carQ;
  assign strInit     = word.stb.init;
  assign strLoad     = word.stb.load;
  assign strClrCarry = word.stb.clrCarry;
  assign strShift    = word.stb.shiftDec;

  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> (curAddr == A_IDLE));
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (curAddr == A_IDLE && !goReq) |=> (curAddr == A_IDLE));
  // R2
  idle_start_chk: assert property (@(posedge clk) disable iff (rst)
    (curAddr == A_IDLE && goReq) |=> (curAddr == A_INIT));
  // R3
  init_next_chk: assert property (@(posedge clk) disable iff (rst)
    (curAddr == A_INIT) |=> (curAddr == A_MUL0));
  // R3
  init_stb_chk: assert property (@(posedge clk) disable iff (rst)
    (curAddr == A_INIT) |-> (strInit && strClrCarry && !strLoad && !strShift));
  // R4
  mul0_add_chk: assert property (@(posedge clk) disable iff (rst)
    (curAddr == A_MUL0 && lsbBit) |=> (curAddr == A_ADD));
  // R4
  mul0_skip_chk: assert property (@(posedge clk) disable iff (rst)
    (curAddr == A_MUL0 && !lsbBit) |=> (curAddr == A_MUL1));
  // R5
  add_next_chk: assert property (@(posedge clk) disable iff (rst)
    (curAddr == A_ADD) |=> (curAddr == A_MUL1));
  // R6
  mul1_done_chk: assert property (@(posedge clk) disable iff (rst)
    (curAddr == A_MUL1 && cntZero) |=> (curAddr == A_IDLE));
  // R6
  mul1_loop_chk: assert property (@(posedge clk) disable iff (rst)
    (curAddr == A_MUL1 && !cntZero) |=> (curAddr == A_MUL0));
  // R7
  stb_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strInit, strLoad, strShift}));
endmodule

// File: tb/sim_usq_seq.sv
`timescale 1ns/1ps
module sim_usq_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic goReq = 1'b0;
  logic forceSt = 1'b0;
  logic forceLsb = 1'b0;
  logic forceZero = 1'b0;
  logic strInit, strLoad, strClrCarry, strShift;
  logic [2:0] curAddr;
  logic lsbBit, cntZero;

  // datapath model
  logic [3:0] dIn;
  logic       ldB = 1'b0, ldQ = 1'b0;
  logic [3:0] regA, regB, regQ;
  logic       regC;
  logic [1:0] regP;

  int checks = 0;
  int fails  = 0;
  int expQ[$];
  logic [2:0] prevAddr = 3'd0;

  always #2.5 clk = ~clk;

  assign lsbBit  = forceSt ? forceLsb  : regQ[0];
  assign cntZero = forceSt ? forceZero : (regP == 2'd0);

  usq_seq u0 (
    .clk(clk), .rst(rst), .goReq(goReq), .lsbBit(lsbBit), .cntZero(cntZero),
    .strInit(strInit), .strLoad(strLoad), .strClrCarry(strClrCarry),
    .strShift(strShift), .curAddr(curAddr)
  );

  always @(posedge clk) begin
    if (ldB) regB <= dIn;
    if (ldQ) regQ <= dIn;
    if (strInit) begin regA <= 4'd0; regP <= 2'd3; end
    if (strLoad) {regC, regA} <= {1'b0, regA} + {1'b0, regB};
    if (strShift) begin
      regA <= {regC, regA[3:1]};
      regQ <= {regA[0], regQ[3:1]};
      regP <= regP - 2'd1;
    end
    if (strClrCarry) regC <= 1'b0;
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // expected strobes {shift, clrCarry, load, init} per address
  function automatic int expStb(logic [2:0] a);
    case (a)
      3'd1: return 4'b0101;
      3'd3: return 4'b0010;
      3'd4: return 4'b1100;
      default: return 4'b0000;
    endcase
  endfunction

  // monitor: strobe pattern each cycle and product on return to IDLE
  always @(negedge clk) begin
    if (!rst && !forceSt) begin
      check(curAddr == 3'd1 ? "R3" : curAddr == 3'd3 ? "R5" : curAddr == 3'd4 ? "R6" : "R2",
            {strShift, strClrCarry, strLoad, strInit}, expStb(curAddr));
      check("R7", int'(strInit) + int'(strLoad) + int'(strShift) <= 1, 1);
      if (prevAddr == 3'd4 && curAddr == 3'd0) begin
        if (expQ.size() == 0) check("R9", 1, 0);
        else check("R9", {regA, regQ}, expQ.pop_front());
      end
    end
    prevAddr = curAddr;
  end

  task automatic runMul(int a, int b);
    int cyc;
    int ones;
    @(negedge clk); ldB = 1'b1; dIn = 4'(a);
    @(negedge clk); ldB = 1'b0; ldQ = 1'b1; dIn = 4'(b);
    @(negedge clk); ldQ = 1'b0; goReq = 1'b1;
    expQ.push_back(a * b);
    @(negedge clk); goReq = 1'b0;
    cyc = 0;
    while (curAddr != 3'd0 && cyc < 40) begin
      cyc++;
      @(negedge clk);
    end
    ones = $countones(4'(b));
    check("R9 cycles", cyc, 1 + 8 + ones);
  endtask

  initial begin
    dIn = 4'd0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 addr", curAddr, 0);
    check("R1 strobes", {strShift, strClrCarry, strLoad, strInit}, 0);
    rst = 1'b0;
    // R2: no start, sequencer holds IDLE
    repeat (4) @(negedge clk);
    check("R2 hold", curAddr, 0);
    // R8: status toggles mid-cycle do not move strobes
    forceSt = 1'b1;
    goReq = 1'b1;
    #0.5;
    @(negedge clk); goReq = 1'b0;
    check("R8 addr", curAddr, 1);
    for (int k = 0; k < 4; k++) begin
      forceLsb = k[0]; forceZero = k[1];
      #0.3;
      check("R8 strobes", {strShift, strClrCarry, strLoad, strInit}, 4'b0101);
    end
    forceLsb = 1'b1; forceZero = 1'b0;
    @(negedge clk); check("R3 next", curAddr, 2);
    for (int k = 0; k < 4; k++) begin
      forceLsb = k[0]; forceZero = k[1];
      #0.3;
      check("R8 strobes", {strShift, strClrCarry, strLoad, strInit}, 0);
    end
    forceLsb = 1'b1;
    @(negedge clk); check("R4 taken", curAddr, 3);
    @(negedge clk); check("R5 next", curAddr, 4);
    forceZero = 1'b0;
    @(negedge clk); check("R6 loop", curAddr, 2);
    forceLsb = 1'b0;
    @(negedge clk); check("R4 skip", curAddr, 4);
    forceZero = 1'b1;
    @(negedge clk); check("R6 done", curAddr, 0);
    // R1: reset in the middle of a sequence
    goReq = 1'b1;
    @(negedge clk); goReq = 1'b0;
    @(negedge clk); check("R3 next", curAddr, 2);
    rst = 1'b1;
    @(negedge clk); check("R1 midrun", curAddr, 0);
    rst = 1'b0; forceSt = 1'b0;
    @(negedge clk);
    // R9: exhaustive 4x4 products
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        runMul(a, b);
    repeat (2) @(negedge clk);
    check("R9 queue empty", expQ.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #150000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule